// File: doc/BRIEF.md
# Multi-Converter ADC Scan Sequencer

This block runs a fixed measurement sweep over several four-input sigma-delta converters that share one two-wire bus. It does not drive the bus pins. Instead it sends byte-level commands to a separate bus engine, one byte at a time. For every input, the sweep has three phases:

1. It writes a configuration word that selects the input and starts a single-shot conversion.
2. It asks an external timer to count out the conversion time.
3. It moves the register pointer to the result register, reads two data bytes and stores the signed value.

Each stored value is tagged with its channel number. It goes into a result bank that can be read at any time. The result is also broadcast on a one-cycle result strobe. Converters are addressed one after another at consecutive bus addresses starting at 1001000b. Inside one converter, inputs 0 to 3 are visited in order before the sweep moves to the next converter.

A sweep starts with a pulse on `scan_start`. If `scan_cont` is high when the last channel finishes, the sweep wraps to channel 0 and keeps going; otherwise the block returns to idle. A 12-bit mode supports the narrower converter family, whose readings arrive left-justified in the 16-bit word. If the bus engine reports a missing acknowledge on any written byte, the current channel is abandoned. Its result is stored as not valid, a sticky error flag records the converter, and the sweep carries on with the next channel.

Top module: `adc_scan_seq`

## Requirements
- R1: The start-conversion transaction for converter `d` is exactly four bytes in this order:
  - address byte `{7'b1001000 + d, 1'b0}`, with a start condition;
  - pointer 01h;
  - configuration high byte;
  - configuration low byte 83h, with a stop condition.
- R2: The configuration high byte for input `c` (0..3) is `{1, 1, c[1:0], 000, 1}`. That is, the start-conversion bit sits at bit 15, the input select `1cc` at bits 14:12, gain 000 at bits 11:9 and single-shot at bit 8. This gives C1h, D1h, E1h and F1h.
- R3: The read transaction is five bytes in this order:
  - address+write (bit 0 = 0), with a start condition;
  - pointer 00h;
  - address+read (bit 0 = 1), with a repeated start;
  - a read byte (`bus_rd`=1), which is the data high byte;
  - a second read byte (`bus_rd`=1) with a stop condition, which is the data low byte.
- R4: Channels are visited in the order tag = 4·converter + input, from tag 0 upward. After the last tag the sweep wraps to tag 0 if `scan_cont` is high; otherwise `scan_busy` drops and no further request, timer start or result appears.
- R5: `tmr_start` is a one-cycle pulse issued only after the configuration low byte completes. No bus request is raised between that pulse and `tmr_done`.
- R6: In 16-bit mode the result is `{high, low}` in two's complement. With `mode12`=1 it is that word shifted right arithmetically by 4, so 7FF0h gives 07FFh and FFF0h gives FFFFh.
- R7: Each channel ends with exactly one single-cycle `res_valid`. The bank entry addressed by `rd_idx` then holds that channel's data and valid bit. Reset clears every bank valid bit.
- R8: A NACK on any written byte ends that channel with no further bytes. The result is stored with `res_ok`=0 and data 0. `err_flag` sets and stays set until reset, `err_dev` shows the converter of the latest NACK, and the next channel follows.
- R9: While `bus_req` is high and `bus_done` has not arrived, the requested byte and its flags do not change.
- R10: After reset the block is idle, with no request, no timer start, no result strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Pulse to begin a sweep at tag 0 when idle |
| scan_cont | input | 1 | Wrap to tag 0 after the last tag instead of stopping |
| mode12 | input | 1 | Treat readings as 12-bit left-justified values |
| bus_req | output | 1 | Byte request to the bus engine, held until done |
| bus_dat | output | 8 | Byte to transmit (0 for read bytes) |
| bus_start_cond | output | 1 | Generate start or repeated start before this byte |
| bus_stop_cond | output | 1 | Generate stop after this byte |
| bus_rd | output | 1 | This byte is received rather than sent |
| bus_done | input | 1 | One-cycle completion of the requested byte |
| bus_nack | input | 1 | With done: the written byte was not acknowledged |
| bus_rdata | input | 8 | With done: the received byte |
| tmr_start | output | 1 | Pulse to start the conversion wait timer |
| tmr_done | input | 1 | Conversion wait has elapsed |
| res_valid | output | 1 | One-cycle result strobe |
| res_tag | output | 4 | Channel tag of the result |
| res_data | output | 16 | Signed result |
| res_ok | output | 1 | Result is a real reading (0 after NACK) |
| err_flag | output | 1 | Sticky NACK flag |
| err_dev | output | 2 | Converter index of the latest NACK |
| scan_busy | output | 1 | Sweep in progress |
| rd_idx | input | 4 | Result bank read index |
| rd_data | output | 16 | Bank data at `rd_idx` |
| rd_ok | output | 1 | Bank valid bit at `rd_idx` |

## Verification
The bench models the bus engine with random latency, and checks every requested byte and its flags against a sequence model of its own. A sequencer that skips the repeated start, mixes up the pointer values or encodes the input select in the wrong bits is therefore caught on the first such byte. Directed readings of FFFFh, 8000h, 7FF0h and FFF0h in both modes expose a logical rather than arithmetic shift, or a swapped byte order. NACKs are forced on the first address byte and on the read-address byte: a design that keeps sending, forgets to mark the entry invalid or reports the wrong converter diverges from the model at the next byte or result. A continuous run dropped mid-sweep must stop exactly at the last tag of that sweep, so wrap and early or late stop errors show up in the result count.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    // Fixed by the converter: four inputs each, 16-bit result register.
    localparam int CH_PER_DEV = 4;
    localparam int CH_W       = 2;
    localparam int RES_W      = 16;
    localparam int STEP_W     = 4;

    // Byte steps of one channel; the order is the bus behaviour.
    localparam logic [STEP_W-1:0] STP_CFG_ADDR = 4'd0;
    localparam logic [STEP_W-1:0] STP_CFG_PTR  = 4'd1;
    localparam logic [STEP_W-1:0] STP_CFG_HI   = 4'd2;
    localparam logic [STEP_W-1:0] STP_CFG_LO   = 4'd3;
    localparam logic [STEP_W-1:0] STP_RD_ADDRW = 4'd4;
    localparam logic [STEP_W-1:0] STP_RD_PTR   = 4'd5;
    localparam logic [STEP_W-1:0] STP_RD_ADDRR = 4'd6;
    localparam logic [STEP_W-1:0] STP_RD_HI    = 4'd7;
    localparam logic [STEP_W-1:0] STP_RD_LO    = 4'd8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_TARM,
        SQ_WAIT,
        SQ_STORE
    } seq_state_e;

    typedef struct packed {
        logic       start_c;
        logic       stop_c;
        logic       rd;
        logic [7:0] dat;
    } bus_cmd_t;

endpackage

// File: rtl/adc_scan_cursor.sv
module adc_scan_cursor
    import adc_scan_pkg::*;
#(
    parameter int NUM_DEV = 4,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    output logic [DEV_W-1:0] dev,
    output logic [CH_W-1:0]  ch,
    output logic            last
);

    localparam logic [DEV_W-1:0] DEV_MAX = DEV_W'(NUM_DEV - 1);
    localparam logic [CH_W-1:0]  CH_MAX  = CH_W'(CH_PER_DEV - 1);

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [CH_W-1:0]  ch;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (clear) begin
            cur_d = '0;
        end else if (advance) begin
            if (cur_q.ch == CH_MAX) begin
                cur_d.ch  = '0;
                cur_d.dev = (cur_q.dev == DEV_MAX) ? '0 : cur_q.dev + 1'b1;
            end else begin
                cur_d.ch = cur_q.ch + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign dev  = cur_q.dev;
    assign ch   = cur_q.ch;
    assign last = (cur_q.dev == DEV_MAX) && (cur_q.ch == CH_MAX);

endmodule

// File: rtl/adc_scan_cmd.sv
module adc_scan_cmd
    import adc_scan_pkg::*;
#(
    parameter int          DEV_W     = 2,
    parameter logic [6:0]  BASE_ADDR = 7'b1001000,
    parameter logic [7:0]  PTR_CFG   = 8'h01,
    parameter logic [7:0]  PTR_CONV  = 8'h00,
    parameter logic [2:0]  GAIN_CODE = 3'b000,
    parameter logic [7:0]  CFG_LO    = 8'h83
) (
    input  logic [STEP_W-1:0] step,
    input  logic [DEV_W-1:0]  dev,
    input  logic [CH_W-1:0]   ch,
    output bus_cmd_t          cmd
);

    logic [6:0] addr7;
    logic [7:0] cfg_hi;

    assign addr7  = BASE_ADDR + 7'(dev);
    // start bit, single-ended select 1cc, gain, single-shot
    assign cfg_hi = {1'b1, 1'b1, ch, GAIN_CODE, 1'b1};

    always_comb begin
        cmd = '0;
        unique case (step)
            STP_CFG_ADDR: cmd = '{start_c: 1'b1, stop_c: 1'b0, rd: 1'b0, dat: {addr7, 1'b0}};
            STP_CFG_PTR:  cmd = '{start_c: 1'b0, stop_c: 1'b0, rd: 1'b0, dat: PTR_CFG};
            STP_CFG_HI:   cmd = '{start_c: 1'b0, stop_c: 1'b0, rd: 1'b0, dat: cfg_hi};
            STP_CFG_LO:   cmd = '{start_c: 1'b0, stop_c: 1'b1, rd: 1'b0, dat: CFG_LO};
            STP_RD_ADDRW: cmd = '{start_c: 1'b1, stop_c: 1'b0, rd: 1'b0, dat: {addr7, 1'b0}};
            STP_RD_PTR:   cmd = '{start_c: 1'b0, stop_c: 1'b0, rd: 1'b0, dat: PTR_CONV};
            STP_RD_ADDRR: cmd = '{start_c: 1'b1, stop_c: 1'b0, rd: 1'b0, dat: {addr7, 1'b1}};
            STP_RD_HI:    cmd = '{start_c: 1'b0, stop_c: 1'b0, rd: 1'b1, dat: 8'h00};
            STP_RD_LO:    cmd = '{start_c: 1'b0, stop_c: 1'b1, rd: 1'b1, dat: 8'h00};
            default:      cmd = '0;
        endcase
    end

endmodule

// File: rtl/adc_scan_bank.sv
module adc_scan_bank #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok
);

    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  ok_d, ok_q;
    logic              rd_in_range;

    always_comb begin
        ok_d = ok_q;
        for (int i = 0; i < DEPTH; i++) data_d[i] = data_q[i];
        if (wr_en) begin
            data_d[wr_idx] = wr_data;
            ok_d[wr_idx]   = wr_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= '0;
            for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
        end else begin
            ok_q <= ok_d;
            for (int i = 0; i < DEPTH; i++) data_q[i] <= data_d[i];
        end
    end

    assign rd_in_range = ({1'b0, rd_idx} < (IDX_W + 1)'(DEPTH));
    assign rd_data     = rd_in_range ? data_q[rd_idx] : '0;
    assign rd_ok       = rd_in_range ? ok_q[rd_idx] : 1'b0;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int         NUM_DEV   = 4,
    parameter logic [6:0] BASE_ADDR = 7'b1001000,
    parameter logic [7:0] CFG_LO    = 8'h83,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int TAG_W = DEV_W + CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_start,
    input  logic             scan_cont,
    input  logic             mode12,
    output logic             bus_req,
    output logic [7:0]       bus_dat,
    output logic             bus_start_cond,
    output logic             bus_stop_cond,
    output logic             bus_rd,
    input  logic             bus_done,
    input  logic             bus_nack,
    input  logic [7:0]       bus_rdata,
    output logic             tmr_start,
    input  logic             tmr_done,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag,
    output logic [RES_W-1:0] res_data,
    output logic             res_ok,
    output logic             err_flag,
    output logic [DEV_W-1:0] err_dev,
    output logic             scan_busy,
    input  logic [TAG_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_ok
);

    localparam int DEPTH = NUM_DEV * CH_PER_DEV;

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
        logic [7:0]        hi;
        logic [RES_W-1:0]  res;
        logic              ok;
        logic              err;
        logic [DEV_W-1:0]  err_dev;
    } seq_t;

    seq_t             s_d, s_q;
    logic             cur_clear, cur_adv, cur_last;
    logic [DEV_W-1:0] cur_dev;
    logic [CH_W-1:0]  cur_ch;
    bus_cmd_t         cmd;
    logic [RES_W-1:0] raw_word, conv_word;

    adc_scan_cursor #(.NUM_DEV(NUM_DEV)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cur_clear),
        .advance (cur_adv),
        .dev     (cur_dev),
        .ch      (cur_ch),
        .last    (cur_last)
    );

    adc_scan_cmd #(
        .DEV_W     (DEV_W),
        .BASE_ADDR (BASE_ADDR),
        .CFG_LO    (CFG_LO)
    ) u_cmd (
        .step (s_q.step),
        .dev  (cur_dev),
        .ch   (cur_ch),
        .cmd  (cmd)
    );

    // Result word: high byte already held, low byte arriving now.
    assign raw_word  = {s_q.hi, bus_rdata};
    assign conv_word = mode12 ? RES_W'($signed(raw_word) >>> 4) : raw_word;

    always_comb begin
        s_d       = s_q;
        cur_clear = 1'b0;
        cur_adv   = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (scan_start) begin
                    s_d.st    = SQ_ISSUE;
                    s_d.step  = STP_CFG_ADDR;
                    cur_clear = 1'b1;
                end
            end
            SQ_ISSUE: begin
                if (bus_done) begin
                    if (!cmd.rd && bus_nack) begin
                        s_d.err     = 1'b1;
                        s_d.err_dev = cur_dev;
                        s_d.ok      = 1'b0;
                        s_d.res     = '0;
                        s_d.st      = SQ_STORE;
                    end else if (s_q.step == STP_CFG_LO) begin
                        s_d.st = SQ_TARM;
                    end else if (s_q.step == STP_RD_LO) begin
                        s_d.res = conv_word;
                        s_d.ok  = 1'b1;
                        s_d.st  = SQ_STORE;
                    end else begin
                        if (s_q.step == STP_RD_HI) s_d.hi = bus_rdata;
                        s_d.step = s_q.step + 1'b1;
                    end
                end
            end
            SQ_TARM: begin
                s_d.st   = SQ_WAIT;
                s_d.step = STP_RD_ADDRW;
            end
            SQ_WAIT: begin
                if (tmr_done) s_d.st = SQ_ISSUE;
            end
            SQ_STORE: begin
                cur_adv  = 1'b1;
                s_d.step = STP_CFG_ADDR;
                s_d.st   = (cur_last && !scan_cont) ? SQ_IDLE : SQ_ISSUE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_req        = (s_q.st == SQ_ISSUE);
    assign bus_dat        = cmd.dat;
    assign bus_start_cond = cmd.start_c;
    assign bus_stop_cond  = cmd.stop_c;
    assign bus_rd         = cmd.rd;
    assign tmr_start      = (s_q.st == SQ_TARM);
    assign res_valid      = (s_q.st == SQ_STORE);
    assign res_tag        = {cur_dev, cur_ch};
    assign res_data       = s_q.res;
    assign res_ok         = s_q.ok;
    assign err_flag       = s_q.err;
    assign err_dev        = s_q.err_dev;
    assign scan_busy      = (s_q.st != SQ_IDLE);

    adc_scan_bank #(.DEPTH(DEPTH), .DATA_W(RES_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_valid),
        .wr_idx  (res_tag),
        .wr_data (s_q.res),
        .wr_ok   (s_q.ok),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rd_ok   (rd_ok)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_done,
    input logic [7:0] bus_dat,
    input logic       bus_rd,
    input logic       tmr_start,
    input logic       tmr_done,
    input logic       res_valid,
    input logic       res_ok,
    input logic       err_flag,
    input logic       scan_busy
);

    logic tmr_armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tmr_armed <= 1'b0;
        else if (tmr_start) tmr_armed <= 1'b1;
        else if (tmr_done)  tmr_armed <= 1'b0;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_dat) && $stable(bus_rd)); // R9

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7

    AST_TIMER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> !tmr_start); // R5

    AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_armed |-> !bus_req); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R8

    AST_BAD_RESULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ok |-> err_flag); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_busy |-> !bus_req && !tmr_start && !res_valid); // R4

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_done  (bus_done),
    .bus_dat   (bus_dat),
    .bus_rd    (bus_rd),
    .tmr_start (tmr_start),
    .tmr_done  (tmr_done),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .err_flag  (err_flag),
    .scan_busy (scan_busy)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 4;
    localparam int NTAG       = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_start, scan_cont, mode12;
    logic        bus_req, bus_start_cond, bus_stop_cond, bus_rd;
    logic [7:0]  bus_dat, bus_rdata;
    logic        bus_done, bus_nack;
    logic        tmr_start, tmr_done;
    logic        res_valid, res_ok, err_flag, scan_busy, rd_ok;
    logic [3:0]  res_tag, rd_idx;
    logic [15:0] res_data, rd_data;
    logic [1:0]  err_dev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .scan_start     (scan_start),
        .scan_cont      (scan_cont),
        .mode12         (mode12),
        .bus_req        (bus_req),
        .bus_dat        (bus_dat),
        .bus_start_cond (bus_start_cond),
        .bus_stop_cond  (bus_stop_cond),
        .bus_rd         (bus_rd),
        .bus_done       (bus_done),
        .bus_nack       (bus_nack),
        .bus_rdata      (bus_rdata),
        .tmr_start      (tmr_start),
        .tmr_done       (tmr_done),
        .res_valid      (res_valid),
        .res_tag        (res_tag),
        .res_data       (res_data),
        .res_ok         (res_ok),
        .err_flag       (err_flag),
        .err_dev        (err_dev),
        .scan_busy      (scan_busy),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data),
        .rd_ok          (rd_ok)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference functions ----------------
    function automatic bit exp_start(input int step);
        return (step == 0) || (step == 4) || (step == 6);
    endfunction
    function automatic bit exp_stop(input int step);
        return (step == 3) || (step == 8);
    endfunction
    function automatic bit exp_rd(input int step);
        return (step == 7) || (step == 8);
    endfunction
    function automatic logic [7:0] exp_byte(input int step, input int dev, input int ch);
        logic [6:0] a;
        a = 7'h48 + 7'(dev);
        case (step)
            0, 4:    return {a, 1'b0};
            1:       return 8'h01;
            2:       return 8'hC1 + 8'(ch * 16);
            3:       return 8'h83;
            5:       return 8'h00;
            6:       return {a, 1'b1};
            default: return 8'h00;
        endcase
    endfunction
    function automatic logic [15:0] exp_conv(input logic [15:0] raw, input bit m12);
        return m12 ? {{4{raw[15]}}, raw[15:4]} : raw;
    endfunction
    function automatic logic [15:0] dir_val(input int tag);
        case (tag)
            0:       return 16'hFFFF;
            1:       return 16'h8000;
            2:       return 16'h7FFF;
            3:       return 16'h0000;
            4:       return 16'h7FF0;
            5:       return 16'hFFF0;
            6:       return 16'h0010;
            default: return 16'(tag * 16'h1111) ^ 16'h5A3C;
        endcase
    endfunction

    // ---------------- bench model state ----------------
    int  m_dev, m_ch, m_step;
    bit  nack_rand = 0;
    bit  dir_data  = 0;
    int  ft0 = -1, fs0 = -1, ft1 = -1, fs1 = -1;
    logic [7:0] m_hi;
    bit  tmr_pend = 0;

    logic [3:0]  f_tag [64];
    logic [15:0] f_dat [64];
    bit          f_ok  [64];
    int          f_wr = 0, f_rd = 0;
    int          results_seen = 0;
    logic [15:0] bank_exp [NTAG];
    bit          bank_ok_exp [NTAG];

    task automatic push_res(input int tag, input bit ok, input logic [15:0] d);
        f_tag[f_wr % 64] = 4'(tag);
        f_ok[f_wr % 64]  = ok;
        f_dat[f_wr % 64] = d;
        f_wr++;
    endtask

    task automatic model_next_channel();
        m_step = 0;
        m_ch++;
        if (m_ch == 4) begin
            m_ch  = 0;
            m_dev = (m_dev + 1) % NDEV;
        end
    endtask

    // ---------------- bus engine model ----------------
    int         e_tag;
    string      e_lbl;
    bit         e_nack;
    logic [7:0] e_rd;
    logic [15:0] e_val;

    initial begin
        bus_done  = 1'b0;
        bus_nack  = 1'b0;
        bus_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (bus_req === 1'b1) begin
                e_tag = m_dev * 4 + m_ch;
                e_lbl = (m_step <= 3) ? ((m_step == 2) ? "R2" : "R1") : "R3";
                chk(bus_start_cond === exp_start(m_step), e_lbl, "start flag",
                    32'(bus_start_cond), 32'(exp_start(m_step)));
                chk(bus_stop_cond === exp_stop(m_step), e_lbl, "stop flag",
                    32'(bus_stop_cond), 32'(exp_stop(m_step)));
                chk(bus_rd === exp_rd(m_step), e_lbl, "read flag",
                    32'(bus_rd), 32'(exp_rd(m_step)));
                if (!exp_rd(m_step))
                    chk(bus_dat === exp_byte(m_step, m_dev, m_ch), e_lbl, "byte value",
                        32'(bus_dat), 32'(exp_byte(m_step, m_dev, m_ch)));
                chk(!tmr_pend, "R5", "request while timer pending", 32'(tmr_pend), 0);
                e_nack = 1'b0;
                if (!exp_rd(m_step))
                    e_nack = (nack_rand && ($urandom_range(9, 0) == 0)) ||
                             (e_tag == ft0 && m_step == fs0) ||
                             (e_tag == ft1 && m_step == fs1);
                e_val = dir_val(e_tag);
                if (dir_data) e_rd = (m_step == 7) ? e_val[15:8] : e_val[7:0];
                else          e_rd = 8'($urandom);
                repeat ($urandom_range(3, 0)) @(negedge clk);
                bus_done  = 1'b1;
                bus_nack  = e_nack;
                bus_rdata = e_rd;
                if (e_nack) begin
                    push_res(e_tag, 1'b0, 16'h0000);
                    model_next_channel();
                end else if (m_step == 8) begin
                    push_res(e_tag, 1'b1, exp_conv({m_hi, e_rd}, mode12));
                    model_next_channel();
                end else begin
                    if (m_step == 7) m_hi = e_rd;
                    m_step++;
                end
                @(negedge clk);
                bus_done = 1'b0;
                bus_nack = 1'b0;
            end
        end
    end

    // ---------------- timer model ----------------
    initial begin
        tmr_done = 1'b0;
        forever begin
            @(negedge clk);
            if (tmr_start === 1'b1) begin
                chk(m_step == 4, "R5", "timer start after config low byte", 32'(m_step), 4);
                tmr_pend = 1'b1;
                @(negedge clk);
                chk(tmr_start === 1'b0, "R5", "timer start single cycle", 32'(tmr_start), 0);
                repeat ($urandom_range(20, 3)) @(negedge clk);
                tmr_done = 1'b1;
                tmr_pend = 1'b0;
                @(negedge clk);
                tmr_done = 1'b0;
            end
        end
    end

    // ---------------- result monitor ----------------
    int mi;
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid === 1'b1) begin
                chk(f_wr != f_rd, "R7", "unexpected result strobe", 32'(res_tag), 0);
                if (f_wr != f_rd) begin
                    mi = f_rd % 64;
                    chk(res_tag === f_tag[mi], "R4", "result tag", 32'(res_tag), 32'(f_tag[mi]));
                    chk(res_ok === f_ok[mi], "R8", "result ok", 32'(res_ok), 32'(f_ok[mi]));
                    chk(res_data === f_dat[mi], "R6", "result data", 32'(res_data), 32'(f_dat[mi]));
                    if (!f_ok[mi])
                        chk(err_flag === 1'b1 && err_dev === f_tag[mi][3:2], "R8", "error device",
                            32'({err_flag, err_dev}), 32'({1'b1, f_tag[mi][3:2]}));
                    bank_exp[f_tag[mi]]    = f_dat[mi];
                    bank_ok_exp[f_tag[mi]] = f_ok[mi];
                    f_rd++;
                end
                results_seen++;
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- directed tasks ----------------
    task automatic check_bank(input string tagline);
        for (int i = 0; i < NTAG; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_ok === bank_ok_exp[i], "R7", {tagline, " bank ok"}, 32'(rd_ok), 32'(bank_ok_exp[i]));
            chk(rd_data === bank_exp[i], "R7", {tagline, " bank data"}, 32'(rd_data), 32'(bank_exp[i]));
        end
    endtask

    task automatic begin_scan(input bit cont);
        m_dev  = 0;
        m_ch   = 0;
        m_step = 0;
        @(negedge clk);
        scan_cont  = cont;
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
    endtask

    task automatic wait_idle_and_quiet();
        while (scan_busy === 1'b1) @(negedge clk);
        chk(f_rd == f_wr, "R4", "all results delivered", 32'(f_rd), 32'(f_wr));
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(!bus_req && !tmr_start && !res_valid, "R4", "quiet after sweep",
                32'({bus_req, tmr_start, res_valid}), 0);
        end
    endtask

    int base;

    initial begin
        void'($urandom(32'd20240611));
        rst_n      = 1'b0;
        scan_start = 1'b0;
        scan_cont  = 1'b0;
        mode12     = 1'b0;
        rd_idx     = '0;
        for (int i = 0; i < NTAG; i++) begin
            bank_exp[i]    = 16'h0000;
            bank_ok_exp[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(bus_req === 1'b0, "R10", "bus_req in reset", 32'(bus_req), 0);
        chk(tmr_start === 1'b0, "R10", "tmr_start in reset", 32'(tmr_start), 0);
        chk(res_valid === 1'b0, "R10", "res_valid in reset", 32'(res_valid), 0);
        chk(err_flag === 1'b0, "R10", "err_flag in reset", 32'(err_flag), 0);
        chk(scan_busy === 1'b0, "R10", "busy in reset", 32'(scan_busy), 0);
        check_bank("reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Pass A: directed corner readings, 16-bit mode, no NACK (R1 R2 R3 R6)
        dir_data = 1;
        mode12   = 1'b0;
        base     = results_seen;
        begin_scan(1'b0);
        wait_idle_and_quiet();
        chk(results_seen == base + NTAG, "R4", "single sweep count", 32'(results_seen - base), NTAG);
        chk(err_flag === 1'b0, "R8", "no error without NACK", 32'(err_flag), 0);
        check_bank("pass A");

        // Pass B: 12-bit mode, left-justified readings (R6)
        mode12 = 1'b1;
        base   = results_seen;
        begin_scan(1'b0);
        wait_idle_and_quiet();
        chk(results_seen == base + NTAG, "R6", "12-bit sweep count", 32'(results_seen - base), NTAG);
        check_bank("pass B");

        // Pass C: forced NACKs on first address byte and read-address byte (R8)
        mode12   = 1'b0;
        dir_data = 0;
        ft0 = 6;  fs0 = 6;
        ft1 = 9;  fs1 = 0;
        base = results_seen;
        begin_scan(1'b0);
        wait_idle_and_quiet();
        chk(results_seen == base + NTAG, "R8", "sweep continues after NACK", 32'(results_seen - base), NTAG);
        chk(err_flag === 1'b1 && err_dev === 2'd2, "R8", "sticky flag and latest device",
            32'({err_flag, err_dev}), 32'({1'b1, 2'd2}));
        check_bank("pass C");
        ft0 = -1; ft1 = -1;

        // Pass D: continuous run with random NACKs, dropped mid second sweep (R4)
        nack_rand = 1;
        base      = results_seen;
        begin_scan(1'b1);
        while (results_seen < base + NTAG + 8) @(negedge clk);
        scan_cont = 1'b0;
        wait_idle_and_quiet();
        chk(results_seen == base + 2 * NTAG, "R4", "continuous wrap then stop",
            32'(results_seen - base), 2 * NTAG);
        chk(err_flag === 1'b1, "R8", "flag still set", 32'(err_flag), 1);
        check_bank("pass D");

        // Pass E: random data in 12-bit mode without NACKs (R6)
        nack_rand = 0;
        mode12    = 1'b1;
        base      = results_seen;
        begin_scan(1'b0);
        wait_idle_and_quiet();
        check_bank("pass E");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule